// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Two-Cycle Valid Selection

This block caches virtual-to-physical page translations in a direct-mapped array of 128 single-way sets. The tag and physical page number of each set are kept in a synchronous memory. The per-set valid flags are kept in flip-flops. Because the memory has one way, each lookup reads only one entry, and the only tag check is a single comparison against the request.

Picking one valid flag out of 128 flip-flops in a single cycle is slow. The block therefore does this selection in two cycles, in step with the memory's one-cycle read.

- **First step.** The upper three index bits choose a 16-flag group, and the group is registered on the edge that samples the lookup.
- **Second step.** The lower four index bits pick the final flag. The tag comparison happens in the same cycle, when the memory data comes back. The response is then registered.

A refill port writes one set and marks it valid. A flush input clears every valid flag in one edge and drops any lookup still in the pipeline. Page walks and permission checks sit outside this block.

Top module: `tlb_twostep_vsel`

## Requirements
- R1: After reset, `rsp_valid` is 0, and a lookup of any address reports a miss.
- R2: A lookup sampled on clock edge E produces exactly one response, with `rsp_valid` high from edge E+1 until edge E+2. Lookups may be issued on every cycle, and their responses come back in order.
- R3: A lookup hits when two conditions hold: the set selected by `lkp_vpn[6:0]` is valid, and its stored tag equals `lkp_vpn[26:7]`. On a hit, `rsp_ppn` carries the stored page number.
- R4: A lookup whose set is valid but whose stored tag differs reports `rsp_hit`=0, with `rsp_ppn`=0.
- R5: A refill writes tag `fill_vpn[26:7]` and `fill_ppn` into set `fill_vpn[6:0]` and marks that set valid. Any earlier entry of that set is replaced.
- R6: A refill to the same set as a lookup makes that lookup report a miss when the refill is sampled on the same edge as the lookup or on the following edge.
- R7: A refill to a different set, made while a lookup is in flight, leaves that lookup's result unchanged.
- R8: After a flush, every set is invalid, and lookups miss until they are refilled.
- R9: A flush sampled on the same edge as a lookup, or on the next edge, suppresses that lookup's response (`rsp_valid` stays 0).
- R10: A refill sampled on the same edge as a flush is discarded.
- R11: All 128 sets are held independently, including sets that share the same lower index bits [3:0] but lie in different groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_vpn | input | 27 | Lookup virtual page number |
| rsp_valid | output | 1 | Response strobe, two edges after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | 24 | Translated physical page number (0 on a miss) |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | 27 | Refill virtual page number (index and tag) |
| fill_ppn | input | 24 | Refill physical page number |
| flush | input | 1 | Invalidate all sets and drop in-flight lookups |

## Verification
The assertions assume that inputs are driven to known levels whenever reset is released. They also assume that the memory content of a set is read only after that set has been refilled once, since the valid flag gates any unwritten data. The bench drives every input on the falling edge and holds the strobes low while reset is asserted. It looks up unfilled sets only to expect misses. The hazard cases place a refill or flush precisely on the lookup's edge or on the one after it, so that both pipeline stages are covered.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_SETS  = 128;
  localparam int unsigned TLB_GROUP = 16;
  localparam int unsigned TLB_VPN_W = 27;
  localparam int unsigned TLB_PPN_W = 24;
endpackage

// File: rtl/tlb_valid_vec.sv
module tlb_valid_vec #(
  parameter int unsigned SETS  = tlb_pkg::TLB_SETS,
  parameter int unsigned GROUP = tlb_pkg::TLB_GROUP,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned NGRP  = SETS / GROUP,
  localparam int unsigned HI_W  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic             rd_en,
  input  logic [HI_W-1:0]  rd_grp,
  output logic [GROUP-1:0] grp_q
);
  logic [SETS-1:0]  vld_q, vld_d, set_mask;
  logic [GROUP-1:0] grp_view [NGRP];
  logic [GROUP-1:0] grp_d;

  // set decoder and group slices
  for (genvar s = 0; s < SETS; s++) begin : g_dec
    assign set_mask[s] = set_en && (set_idx == IDX_W'(s));
  end
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_view[g] = vld_q[g*GROUP +: GROUP];
  end

  always_comb begin
    if (clr_all) vld_d = '0;
    else         vld_d = vld_q | set_mask;
  end

  always_comb begin
    grp_d = grp_q;
    if (rd_en) grp_d = grp_view[rd_grp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      grp_q <= '0;
    end else begin
      vld_q <= vld_d;
      grp_q <= grp_d;
    end
  end

  // R11
  set_dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_mask));
endmodule

// File: rtl/tlb_sram.sv
module tlb_sram #(
  parameter int unsigned DEPTH = tlb_pkg::TLB_SETS,
  parameter int unsigned WIDTH = 44,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tlb_resp.sv
module tlb_resp #(
  parameter int unsigned GROUP = tlb_pkg::TLB_GROUP,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned PPN_W = tlb_pkg::TLB_PPN_W,
  localparam int unsigned LO_W = $clog2(GROUP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [IDX_W-1:0] s1_idx,
  input  logic [TAG_W-1:0] s1_tag,
  input  logic             s1_kill,
  input  logic [GROUP-1:0] grp_bits,
  input  logic [TAG_W-1:0] mem_tag,
  input  logic [PPN_W-1:0] mem_ppn,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             flush,
  output logic             rsp_valid_q,
  output logic             rsp_hit_q,
  output logic [PPN_W-1:0] rsp_ppn_q
);
  logic             vbit, tag_eq, hazard, hit_d, vld_d;
  logic [PPN_W-1:0] ppn_d;
  logic [LO_W-1:0]  lo;

  assign lo = s1_idx[LO_W-1:0];

  always_comb begin
    vbit   = grp_bits[lo];
    tag_eq = (mem_tag == s1_tag);
    hazard = s1_kill || (fill_en && (fill_idx == s1_idx));
    vld_d  = s1_valid && !flush;
    hit_d  = vld_d && vbit && tag_eq && !hazard;
    ppn_d  = hit_d ? mem_ppn : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_ppn_q   <= '0;
    end else begin
      rsp_valid_q <= vld_d;
      rsp_hit_q   <= hit_d;
      rsp_ppn_q   <= ppn_d;
    end
  end

  // R3
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit_q |-> rsp_valid_q);
endmodule

// File: rtl/tlb_twostep_vsel.sv
module tlb_twostep_vsel #(
  parameter int unsigned SETS  = tlb_pkg::TLB_SETS,
  parameter int unsigned GROUP = tlb_pkg::TLB_GROUP,
  parameter int unsigned VPN_W = tlb_pkg::TLB_VPN_W,
  parameter int unsigned PPN_W = tlb_pkg::TLB_PPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_valid,
  input  logic [VPN_W-1:0] lkp_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned LO_W  = $clog2(GROUP);
  localparam int unsigned NGRP  = SETS / GROUP;
  localparam int unsigned HI_W  = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned ENT_W = TAG_W + PPN_W;

  logic [IDX_W-1:0] lkp_idx, fill_idx;
  logic [TAG_W-1:0] lkp_tag, fill_tag;
  logic [HI_W-1:0]  lkp_grp;
  logic             fill_en;

  logic             s1_valid_q, s1_valid_d, s1_kill_q, s1_kill_d;
  logic [IDX_W-1:0] s1_idx_q, s1_idx_d;
  logic [TAG_W-1:0] s1_tag_q, s1_tag_d;

  logic [GROUP-1:0] grp_bits;
  logic [ENT_W-1:0] mem_rd;

  assign lkp_idx  = lkp_vpn[IDX_W-1:0];
  assign lkp_tag  = lkp_vpn[VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:IDX_W];
  assign fill_en  = fill_valid && !flush;

  if (NGRP > 1) begin : g_hi
    assign lkp_grp = lkp_idx[IDX_W-1:LO_W];
  end else begin : g_nohi
    assign lkp_grp = '0;
  end

  tlb_valid_vec #(.SETS(SETS), .GROUP(GROUP)) u_vvec (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (fill_en),
    .set_idx (fill_idx),
    .clr_all (flush),
    .rd_en   (lkp_valid),
    .rd_grp  (lkp_grp),
    .grp_q   (grp_bits)
  );

  tlb_sram #(.DEPTH(SETS), .WIDTH(ENT_W)) u_mem (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_addr (fill_idx),
    .wr_data ({fill_tag, fill_ppn}),
    .rd_en   (lkp_valid),
    .rd_addr (lkp_idx),
    .rd_data (mem_rd)
  );

  // stage-1 capture
  always_comb begin
    s1_valid_d = lkp_valid && !flush;
    s1_kill_d  = fill_en && (fill_idx == lkp_idx);
    s1_idx_d   = s1_idx_q;
    s1_tag_d   = s1_tag_q;
    if (lkp_valid) begin
      s1_idx_d = lkp_idx;
      s1_tag_d = lkp_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_kill_q  <= 1'b0;
      s1_idx_q   <= '0;
      s1_tag_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_kill_q  <= s1_kill_d;
      s1_idx_q   <= s1_idx_d;
      s1_tag_q   <= s1_tag_d;
    end
  end

  tlb_resp #(.GROUP(GROUP), .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .s1_valid    (s1_valid_q),
    .s1_idx      (s1_idx_q),
    .s1_tag      (s1_tag_q),
    .s1_kill     (s1_kill_q),
    .grp_bits    (grp_bits),
    .mem_tag     (mem_rd[ENT_W-1:PPN_W]),
    .mem_ppn     (mem_rd[PPN_W-1:0]),
    .fill_en     (fill_en),
    .fill_idx    (fill_idx),
    .flush       (flush),
    .rsp_valid_q (rsp_valid),
    .rsp_hit_q   (rsp_hit),
    .rsp_ppn_q   (rsp_ppn)
  );

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lkp_valid, 2));

  // R9
  flush_kills_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rsp_valid);

  // R6
  fill_hazard_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && s1_valid_q && (fill_idx == s1_idx_q)) |=> !rsp_hit);
endmodule

// File: tb/tlb_twostep_vsel_bench.sv
module tlb_twostep_vsel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkp_valid, fill_valid, flush;
  logic [26:0] lkp_vpn, fill_vpn;
  logic [23:0] fill_ppn;
  logic        rsp_valid, rsp_hit;
  logic [23:0] rsp_ppn;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_twostep_vsel u_tlb_twostep_vsel (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .flush(flush)
  );

  function automatic logic [26:0] mk(input logic [19:0] tag, input logic [6:0] idx);
    return {tag, idx};
  endfunction

  function automatic logic [23:0] pp(input logic [26:0] v);
    return v[23:0] ^ 24'h5A_3C_96;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [26:0] v);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = pp(v);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [26:0] v, input bit exp_hit, input string req);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = v;
    @(negedge clk);
    lkp_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, rsp_valid, 1);
    check({req, " hit"}, rsp_hit, exp_hit);
    check({req, " ppn"}, rsp_ppn, exp_hit ? pp(v) : 24'h0);
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", rsp_valid, 0);
    look(mk(20'h0, 7'h00), 0, "R1 cold lookup");
    look(mk(20'hABCDE, 7'h55), 0, "R1 cold lookup 2");
  endtask

  task automatic t_fill_hit;
    fill(mk(20'h12345, 7'h05));
    look(mk(20'h12345, 7'h05), 1, "R3 hit");
    look(mk(20'h12344, 7'h05), 0, "R4 tag mismatch");
  endtask

  task automatic t_replace;
    fill(mk(20'h77777, 7'h05));
    look(mk(20'h12345, 7'h05), 0, "R5 old entry replaced");
    look(mk(20'h77777, 7'h05), 1, "R5 new entry");
  endtask

  task automatic t_groups;
    for (int g = 0; g < 8; g++) fill(mk(20'h100 + 20'(g), 7'((g << 4) | 3)));
    for (int g = 0; g < 8; g++) look(mk(20'h100 + 20'(g), 7'((g << 4) | 3)), 1, "R11 group set");
    look(mk(20'h100, 7'h13), 0, "R11 cross-group tag");
    look(mk(20'h100, 7'h04), 0, "R11 neighbour unfilled");
  endtask

  task automatic t_pipeline;
    logic [26:0] pv [8];
    bit          ph [8];
    for (int i = 0; i < 8; i++) begin
      pv[i] = (i % 2 == 0) ? mk(20'h100 + 20'(i), 7'((i << 4) | 3)) : mk(20'hFFFFF, 7'(i + 64));
      ph[i] = (i % 2 == 0);
    end
    for (int k = 0; k <= 10; k++) begin
      @(negedge clk);
      if (k >= 2 && k < 10) begin
        check("R2 stream valid", rsp_valid, 1);
        check("R2 stream hit", rsp_hit, ph[k-2]);
        check("R2 stream ppn", rsp_ppn, ph[k-2] ? pp(pv[k-2]) : 24'h0);
      end else if (k == 1 || k == 10) begin
        check("R2 no extra response", rsp_valid, 0);
      end
      if (k < 8) begin lkp_valid = 1'b1; lkp_vpn = pv[k]; end
      else lkp_valid = 1'b0;
    end
  endtask

  task automatic t_haz_same;
    fill(mk(20'h2222, 7'h30));
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = mk(20'h2222, 7'h30);
    fill_valid = 1'b1; fill_vpn = mk(20'h2222, 7'h30); fill_ppn = pp(fill_vpn);
    @(negedge clk);
    lkp_valid = 1'b0; fill_valid = 1'b0;
    @(negedge clk);
    check("R6 same-edge refill valid", rsp_valid, 1);
    check("R6 same-edge refill miss", rsp_hit, 0);
  endtask

  task automatic t_haz_next;
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = mk(20'h2222, 7'h30);
    @(negedge clk);
    lkp_valid = 1'b0;
    fill_valid = 1'b1; fill_vpn = mk(20'h2222, 7'h30); fill_ppn = pp(fill_vpn);
    @(negedge clk);
    fill_valid = 1'b0;
    check("R6 next-edge refill valid", rsp_valid, 1);
    check("R6 next-edge refill miss", rsp_hit, 0);
  endtask

  task automatic t_haz_other;
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = mk(20'h2222, 7'h30);
    fill_valid = 1'b1; fill_vpn = mk(20'h3333, 7'h31); fill_ppn = pp(fill_vpn);
    @(negedge clk);
    lkp_valid = 1'b0;
    fill_vpn = mk(20'h4444, 7'h20); fill_ppn = pp(fill_vpn);
    @(negedge clk);
    fill_valid = 1'b0;
    check("R7 other-set refill hit", rsp_hit, 1);
    check("R7 other-set refill ppn", rsp_ppn, pp(mk(20'h2222, 7'h30)));
    look(mk(20'h3333, 7'h31), 1, "R7 other-set written");
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    look(mk(20'h2222, 7'h30), 0, "R8 after flush");
    look(mk(20'h100, 7'h03), 0, "R8 after flush g0");
    fill(mk(20'h2222, 7'h30));
    look(mk(20'h2222, 7'h30), 1, "R8 refill after flush");
  endtask

  task automatic t_flush_kill;
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = mk(20'h2222, 7'h30); flush = 1'b1;
    @(negedge clk);
    lkp_valid = 1'b0; flush = 1'b0;
    @(negedge clk);
    check("R9 same-edge flush no rsp", rsp_valid, 0);
    fill(mk(20'h2222, 7'h30));
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = mk(20'h2222, 7'h30);
    @(negedge clk);
    lkp_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R9 next-edge flush no rsp", rsp_valid, 0);
  endtask

  task automatic t_flush_fill;
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = mk(20'h5555, 7'h7F); fill_ppn = pp(fill_vpn);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look(mk(20'h5555, 7'h7F), 0, "R10 refill under flush dropped");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lkp_valid = 1'b0; lkp_vpn = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0;
    flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill_hit;
    t_replace;
    t_groups;
    t_pipeline;
    t_haz_same;
    t_haz_next;
    t_haz_other;
    t_flush;
    t_flush_kill;
    t_flush_fill;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule